// File: doc/BRIEF.md
# Half-Cycle Read Capture Window Timer

This block produces the enables that open the read-data capture window after each READ command leaves the memory controller. A 4-bit linear latency code, counted in half clock cycles, places the start of the window. Odd codes land the start on a falling clock edge, so the window is reported on a separate falling-edge enable. Even codes use the rising-edge enable. The window always lasts `WIN_LEN` whole cycles. The latency code only moves its start.

Each read-issue strobe takes its latency code at the moment it is issued. The block places that read's window into its own shift lane, so reads issued back to back each get a window and none is dropped. Windows that overlap merge into one continuous enable. Codes 0 and 1 are not valid latencies. A read issued with one of them is timed as a one-cycle latency and sets a sticky error flag.

The internal structure is a decoder for the latency code, two shift lanes (one per clock edge) and a small two-state error machine. The error machine has state `ERR_CLEAR` after reset. On the transition *reserved read seen* it moves to `ERR_LATCHED`, and only reset takes it back to `ERR_CLEAR`.

Top module: `rd_capture_window`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cap_rise_en`, `cap_fall_en` and `lat_err` are all 0.
- R2: Consider a read issued at clock edge E with an even code c in 2..14, and let W = c/2. `cap_rise_en` is 1 from the cycle after edge E+W-1 through the cycle after edge E+W+WIN_LEN-2, and that read never raises `cap_fall_en`.
- R3: Consider a read issued at clock edge E with an odd code c in 3..15, and let W = c>>1. `cap_fall_en` follows the same cycles as in R2, and that read never raises `cap_rise_en`.
- R4: Every window lasts exactly WIN_LEN cycles, whatever the code. Any enable is high only within DEPTH = 7+WIN_LEN-1 cycles of the latest read issue.
- R5: A read issued with code 0 or 1 is timed exactly like code 2: a rising-edge window opens in the cycle right after the issue edge.
- R6: A read issued with code 0 or 1 sets `lat_err` from the cycle after the issue edge. `lat_err` then stays at 1 until reset.
- R7: A latency code on `lat_code` with `rd_issue` low has no effect: no enable opens and `lat_err` does not change.
- R8: Reads issued on consecutive cycles each get their own window. Where windows on the same edge overlap or touch, the enable stays high without a gap.
- R9: Each read's latency is sampled at its issue edge. A later change of `lat_code` does not move a window that is already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_issue | input | 1 | One-cycle strobe per READ command sent |
| lat_code | input | 4 | Linear read latency in half cycles, sampled with `rd_issue` |
| cap_rise_en | output | 1 | Capture enable for rising-edge data |
| cap_fall_en | output | 1 | Capture enable for falling-edge data |
| lat_err | output | 1 | Sticky flag: a read used a reserved latency code |

## Verification
The assertions check on every cycle the properties that follow directly from a single issue edge:
- the sticky nature of the error flag and its rise after a reserved-code read;
- that no error appears without such a read;
- the one-cycle openings for codes 0 to 3;
- the bound that ties any open enable to a recent read.

Only the bench's scenarios can show the following:
- the exact start and end cycle for every code;
- the fixed window length;
- the merging of back-to-back windows;
- that a pending window holds its place when the code changes;
- that reset clears the flag.

// File: rtl/cwin_pkg.sv
package cwin_pkg;

    localparam int CODE_W  = 4;
    localparam int WHOLE_W = CODE_W - 1;
    localparam int MAX_WHOLE = ((1 << CODE_W) - 1) >> 1;

    // decoded read latency
    typedef struct packed {
        logic [WHOLE_W-1:0] whole;
        logic               half;
        logic               reserved;
    } lat_t;

    typedef enum logic {
        ERR_CLEAR   = 1'b0,
        ERR_LATCHED = 1'b1
    } err_state_t;

endpackage

// File: rtl/cwin_lat_decode.sv
module cwin_lat_decode
    import cwin_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output lat_t              lat
);

    always_comb begin
        lat.reserved = (code < CODE_W'(2));
        if (lat.reserved) begin
            // clamp to a one-cycle latency on the rising edge
            lat.whole = WHOLE_W'(1);
            lat.half  = 1'b0;
        end else begin
            lat.whole = code[CODE_W-1:1];
            lat.half  = code[0];
        end
    end

endmodule

// File: rtl/cwin_lane.sv
module cwin_lane #(
    parameter int DEPTH   = 8,
    parameter int WIN_LEN = 2,
    parameter int START_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [START_W-1:0] start,
    output logic               en
);

    logic [DEPTH-1:0] slots;
    logic [DEPTH-1:0] mask;

    // one bit per future cycle; slot 0 is the current cycle
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mask[i] = load && (i >= int'(start)) && (i < int'(start) + WIN_LEN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots <= '0;
        end else begin
            slots <= (slots >> 1) | mask;
        end
    end

    assign en = slots[0];

endmodule

// File: rtl/cwin_err_fsm.sv
module cwin_err_fsm
    import cwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bad_read,
    output logic err
);

    err_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ERR_CLEAR;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        err      = 1'b0;
        unique case (state)
            ERR_CLEAR: begin
                if (bad_read) begin
                    state_nx = ERR_LATCHED;
                end
            end
            ERR_LATCHED: begin
                err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rd_capture_window.sv
module rd_capture_window
    import cwin_pkg::*;
#(
    parameter int WIN_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [CODE_W-1:0] lat_code,
    output logic              cap_rise_en,
    output logic              cap_fall_en,
    output logic              lat_err
);

    localparam int DEPTH = MAX_WHOLE + WIN_LEN - 1;
    localparam int NLANE = 2;

    lat_t               lat;
    logic [WHOLE_W-1:0] start;
    logic [NLANE-1:0]   lane_en;

    cwin_lat_decode u_dec (
        .code (lat_code),
        .lat  (lat)
    );

    // whole-cycle latency W opens the window in slot W-1
    assign start = lat.whole - WHOLE_W'(1);

    // lane 0 serves rising-edge capture, lane 1 falling-edge capture
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        cwin_lane #(
            .DEPTH   (DEPTH),
            .WIN_LEN (WIN_LEN),
            .START_W (WHOLE_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (rd_issue && (lat.half == g[0])),
            .start (start),
            .en    (lane_en[g])
        );
    end

    cwin_err_fsm u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .bad_read (rd_issue && lat.reserved),
        .err      (lat_err)
    );

    assign cap_rise_en = lane_en[0];
    assign cap_fall_en = lane_en[1];

endmodule

// File: rtl/rd_capture_window_chk.sv
module rd_capture_window_chk #(
    parameter int WIN_LEN = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_issue,
    input logic [3:0] lat_code,
    input logic       cap_rise_en,
    input logic       cap_fall_en,
    input logic       lat_err
);

    localparam int DEPTH = 7 + WIN_LEN - 1;

    int unsigned since_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rd <= DEPTH;
        end else if (rd_issue) begin
            since_rd <= 0;
        end else if (since_rd < DEPTH) begin
            since_rd <= since_rd + 1;
        end
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lat_err |=> lat_err);

    assert_err_on_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && lat_code < 4'd2) |=> lat_err);

    assert_no_spurious_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_err && !(rd_issue && lat_code < 4'd2)) |=> !lat_err);

    assert_reserved_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && lat_code < 4'd2) |=> cap_rise_en);

    assert_one_cycle_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && lat_code == 4'd2) |=> cap_rise_en);

    assert_one_half_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && lat_code == 4'd3) |=> cap_fall_en);

    assert_window_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rise_en || cap_fall_en) |-> (since_rd < DEPTH));

endmodule

bind rd_capture_window rd_capture_window_chk #(.WIN_LEN(WIN_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_issue    (rd_issue),
    .lat_code    (lat_code),
    .cap_rise_en (cap_rise_en),
    .cap_fall_en (cap_fall_en),
    .lat_err     (lat_err)
);

// File: tb/sim_rd_capture_window.sv
`timescale 1ns/1ps
module sim_rd_capture_window;

    localparam int LEN    = 2;
    localparam int MAXRD  = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_issue = 1'b0;
    logic [3:0] lat_code = 4'd0;
    logic       cap_rise_en, cap_fall_en, lat_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int nr       = 0;
    int iss_cyc [MAXRD];
    int iss_code[MAXRD];
    bit done     = 0;

    always #4 clk = ~clk;

    rd_capture_window #(.WIN_LEN(LEN)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_issue    (rd_issue),
        .lat_code    (lat_code),
        .cap_rise_en (cap_rise_en),
        .cap_fall_en (cap_fall_en),
        .lat_err     (lat_err)
    );

    // record each issue edge with its code
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n && rd_issue && nr < MAXRD) begin
            iss_cyc[nr]  = cyc;
            iss_code[nr] = lat_code;
            nr = nr + 1;
        end
    end

    task automatic cmp(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // expected outputs from the requirement formulas over all recorded reads
    task automatic check_now(string tag);
        logic er = 0, ef = 0, ee = 0;
        for (int i = 0; i < nr; i++) begin
            int ec = (iss_code[i] < 2) ? 2 : iss_code[i];
            int w  = ec / 2;
            int m  = cyc - iss_cyc[i];
            if (m >= w - 1 && m <= w + LEN - 2) begin
                if (ec % 2 == 1) ef = 1; else er = 1;
            end
            if (iss_code[i] < 2) ee = 1;
        end
        cmp(tag, "cap_rise_en", cap_rise_en, er);
        cmp(tag, "cap_fall_en", cap_fall_en, ef);
        cmp(tag, "lat_err", lat_err, ee);
    endtask

    task automatic step_check(int n, string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_now(tag);
        end
    endtask

    task automatic issue(int code, string tag);
        @(negedge clk);
        rd_issue = 1'b1;
        lat_code = 4'(code);
        @(negedge clk);
        rd_issue = 1'b0;
        check_now(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        nr = 0;
        #1;
        cmp("R1", "cap_rise_en in reset", cap_rise_en, 1'b0);
        cmp("R1", "cap_fall_en in reset", cap_fall_en, 1'b0);
        cmp("R1", "lat_err in reset", lat_err, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step_check(1, "R1");
    endtask

    task automatic t_even();
        for (int c = 2; c <= 14; c += 2) begin
            issue(c, "R2");
            step_check(10, "R2");
        end
    endtask

    task automatic t_odd();
        for (int c = 3; c <= 15; c += 2) begin
            issue(c, "R3");
            step_check(10, "R3");
        end
    endtask

    task automatic t_idle_code();
        @(negedge clk);
        lat_code = 4'd0;
        step_check(4, "R7");
        lat_code = 4'd1;
        step_check(4, "R7");
    endtask

    task automatic t_back_to_back();
        // three consecutive reads, code 4: windows merge (R8)
        @(negedge clk); rd_issue = 1'b1; lat_code = 4'd4;
        step_check(3, "R8");
        rd_issue = 1'b0;
        step_check(10, "R8");
        // mixed edges overlapping
        @(negedge clk); rd_issue = 1'b1; lat_code = 4'd5;
        @(negedge clk); lat_code = 4'd6; check_now("R8");
        @(negedge clk); rd_issue = 1'b0; check_now("R8");
        step_check(10, "R8");
        // pending window holds when code changes (R9)
        @(negedge clk); rd_issue = 1'b1; lat_code = 4'd14;
        @(negedge clk); lat_code = 4'd2; check_now("R9");
        @(negedge clk); rd_issue = 1'b0; lat_code = 4'd9; check_now("R9");
        step_check(10, "R9");
    endtask

    task automatic t_reserved();
        issue(0, "R5");
        step_check(4, "R5");
        issue(1, "R6");
        step_check(4, "R6");
        issue(8, "R6");
        step_check(6, "R6");
        do_reset();
        cmp("R6", "lat_err cleared by reset", lat_err, 1'b0);
        step_check(3, "R6");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_even();
        t_odd();
        t_idle_code();
        t_back_to_back();
        t_reserved();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule